// File: doc/BRIEF.md
# Bus-Master DMA Channel

This block is a single direction of a bus-master bridge that sits between a local add-on bus and a simple 32-bit memory-mapped initiator port. It buffers words in a small FIFO and keeps one transfer address register and one byte count register. Once enabled, it asks an arbiter for the bus, waits for a grant, and then moves one word per beat. After each acknowledged beat the address goes up and the count goes down. An interrupt flag is raised when the count runs out or when the target reports an error. The initiator port only carries memory cycles. It has no I/O-space signalling at all.

A parameter fixes the direction of each instance. In the toward-memory direction, the add-on side fills the FIFO and the beats are memory writes. In the from-memory direction, the beats are memory reads that fill the FIFO, and the add-on side drains it. A configuration byte is captured while reset is held. Bit 7 decides which side may program the address and count registers. Bit 6 sets the add-on read strobe mode and bit 5 sets the add-on write strobe mode. Each strobe can act as a clock-sampled level enable or as an edge-clocked pulse.

Top module: `dma_chan`

## Requirements
- R1: The FIFO holds DEPTH (default 8) words of DW (default 32) bits. A push while it is full is ignored. A pop while it is empty is ignored, and `ao_rd_data` keeps its last value.
- R2: Bit 7 of the configuration selects the register owner: 1 means host side (`host_*` ports) and 0 means add-on side (`ao_we`/`ao_sel`/`ao_wdata`). Writes from the other side have no effect. Select 0 addresses the address register and select 1 addresses the count register.
- R3: The configuration byte is captured only while `rst` is high. Changing `cfg_byte` afterwards has no effect on ownership or strobe modes.
- R4: Bit 5 sets the write strobe `ao_wr_n` (active low) mode. With 0, every clock edge that samples it low pushes `ao_wr_data`. With 1, each high-to-low transition pushes exactly one word, however long the low phase lasts. The word is taken at the third clock edge after the falling transition.
- R5: Bit 6 sets the read strobe `ao_rd_n` mode in the same way. Each pop loads the oldest word into `ao_rd_data`, where it is visible from the cycle after the pop.
- R6: `bus_req` is high only while all of these hold: `chan_en` is high, the count is nonzero, no error is latched, and the FIFO is non-empty (toward memory) or not full (from memory). It drops when any of them fails.
- R7: A beat begins, with `bus_valid` rising, only in the cycle after `bus_gnt` was sampled high while requesting. `bus_addr`, `bus_we` (1 toward memory, 0 from memory) and `bus_wdata` (oldest FIFO word) stay stable until `bus_ack` or `bus_err`.
- R8: Each acknowledged beat adds 4 to the address and subtracts 4 from the byte count. The two low bits of a written count are cleared.
- R9: When the count reaches zero, `irq_done` is set and the request is dropped. A count write from the owner clears `irq_done` and `irq_err`.
- R10: A beat answered with `bus_err` sets `irq_err` and stops requesting. The address, the count and the FIFO are left unchanged, so rewriting the count retries the same word at the same address.
- R11: In the from-memory direction, an empty FIFO with a large count gets exactly DEPTH beats. The channel then waits until the add-on frees space, and then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `cfg_byte` |
| cfg_byte | input | 8 | Configuration: bit 7 owner, bit 6 read strobe mode, bit 5 write strobe mode |
| chan_en | input | 1 | Channel enable |
| host_we | input | 1 | Host-side register write |
| host_sel | input | 1 | Host-side register select (0 address, 1 count) |
| host_wdata | input | 32 | Host-side register write data |
| ao_we | input | 1 | Add-on-side register write |
| ao_sel | input | 1 | Add-on-side register select (0 address, 1 count) |
| ao_wdata | input | 32 | Add-on-side register write data |
| ao_wr_n | input | 1 | Add-on write strobe, active low |
| ao_wr_data | input | 32 | Add-on write data |
| ao_rd_n | input | 1 | Add-on read strobe, active low |
| ao_rd_data | output | 32 | Last word popped toward the add-on |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | Beat in progress |
| bus_we | output | 1 | Beat direction: 1 memory write, 0 memory read |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 32 | Beat write data |
| bus_rdata | input | 32 | Beat read data, taken with `bus_ack` |
| bus_ack | input | 1 | Target completed the beat |
| bus_err | input | 1 | Target failed the beat |
| irq_done | output | 1 | Count-expired interrupt flag |
| irq_err | output | 1 | Bus-error interrupt flag |

## Verification
Two instances run side by side. The first moves data toward memory, with host ownership and edge strobes. The second moves data from memory, with add-on ownership and level strobes. After reset both configuration bytes are swapped, so any sensitivity to late changes shows up as wrong data or wrong beat counts. In the toward-memory direction a long low pulse and single-cycle pulses are sent. This separates edge behaviour from level behaviour, because a level-sensitive design would push extra words. An error response followed by a retry shows whether the address, the count and the FIFO head survived the failed beat. In the from-memory direction a transfer longer than the FIFO shows that the request stops when the FIFO is full and resumes after two pops. A pop on an empty FIFO shows that the read data holds its last value.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BEAT = 2'd2
  } bus_st_e;

  localparam int CFG_OWN_BIT     = 7;
  localparam int CFG_RD_EDGE_BIT = 6;
  localparam int CFG_WR_EDGE_BIT = 5;

  localparam logic SEL_ADDR = 1'b0;
  localparam logic SEL_CNT  = 1'b1;

  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R1
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop |=> full && $stable(wp));

  // R1
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push |=> empty && $stable(rp));
endmodule

// File: rtl/dma_strobe.sv
module dma_strobe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_mode,
  input  logic strobe_n,
  output logic fire
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], strobe_n};
  end

  always_comb begin
    if (edge_mode) fire = sh[STAGES] & ~sh[STAGES-1];
    else           fire = ~strobe_n;
  end

  // R4
  one_fire_chk: assert property (@(posedge clk) disable iff (rst)
    edge_mode && fire |=> !fire);
endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          own_host,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [AW-1:0] host_wdata,
  input  logic          ao_we,
  input  logic          ao_sel,
  input  logic [AW-1:0] ao_wdata,
  input  logic          advance,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] cnt_q,
  output logic          cnt_wr
);
  import dma_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic          wr;
  logic          sel;
  logic [AW-1:0] wd;

  assign wr     = own_host ? host_we : ao_we;
  assign sel    = own_host ? host_sel : ao_sel;
  assign wd     = own_host ? host_wdata : ao_wdata;
  assign cnt_wr = wr && (sel == SEL_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (wr) begin
      if (sel == SEL_ADDR) addr_q <= wd;
      else                 cnt_q  <= {wd[AW-1:2], 2'b00};
    end else if (advance) begin
      addr_q <= addr_q + STEP;
      cnt_q  <= cnt_q - STEP;
    end
  end

  // R8
  adv_step_chk: assert property (@(posedge clk) disable iff (rst)
    advance && !wr |=> addr_q == $past(addr_q) + STEP && cnt_q == $past(cnt_q) - STEP);

  // R2
  foreign_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !advance && !(own_host ? host_we : ao_we) |=> $stable(addr_q) && $stable(cnt_q));
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int DEPTH  = 8,
  parameter int STAGES = 2,
  parameter bit TO_MEM = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    cfg_byte,
  input  logic          chan_en,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [AW-1:0] host_wdata,
  input  logic          ao_we,
  input  logic          ao_sel,
  input  logic [AW-1:0] ao_wdata,
  input  logic          ao_wr_n,
  input  logic [DW-1:0] ao_wr_data,
  input  logic          ao_rd_n,
  output logic [DW-1:0] ao_rd_data,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          irq_done,
  output logic          irq_err
);
  import dma_pkg::*;

  localparam logic [AW-1:0] LAST_BEAT = AW'(WORD_BYTES);

  logic          own_q, rd_edge_q, wr_edge_q;
  logic          wr_fire, rd_fire;
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0] fifo_din, fifo_head;
  logic [AW-1:0] addr_q, cnt_q;
  logic          cnt_wr;
  logic          beat_ok, space_ok, go;
  bus_st_e       st;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q     <= cfg_byte[CFG_OWN_BIT];
      rd_edge_q <= cfg_byte[CFG_RD_EDGE_BIT];
      wr_edge_q <= cfg_byte[CFG_WR_EDGE_BIT];
    end
  end

  dma_strobe #(.STAGES(STAGES)) u_wr_stb (
    .clk(clk), .rst(rst), .edge_mode(wr_edge_q), .strobe_n(ao_wr_n), .fire(wr_fire)
  );

  dma_strobe #(.STAGES(STAGES)) u_rd_stb (
    .clk(clk), .rst(rst), .edge_mode(rd_edge_q), .strobe_n(ao_rd_n), .fire(rd_fire)
  );

  dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .wdata(fifo_din), .pop(fifo_pop),
    .head(fifo_head), .full(fifo_full), .empty(fifo_empty)
  );

  dma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .own_host(own_q),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .ao_we(ao_we), .ao_sel(ao_sel), .ao_wdata(ao_wdata),
    .advance(beat_ok), .addr_q(addr_q), .cnt_q(cnt_q), .cnt_wr(cnt_wr)
  );

  assign beat_ok = (st == ST_BEAT) && bus_ack && !bus_err;
  assign bus_we  = TO_MEM;

  generate
    if (TO_MEM) begin : g_to_mem
      logic unused_side;
      assign unused_side = &{1'b0, rd_fire, bus_rdata, cfg_byte[4:0]};
      assign fifo_push = wr_fire;
      assign fifo_din  = ao_wr_data;
      assign fifo_pop  = beat_ok;
      assign space_ok  = !fifo_empty;
      always_comb ao_rd_data = '0;
    end else begin : g_from_mem
      logic unused_side;
      assign unused_side = &{1'b0, wr_fire, ao_wr_data, cfg_byte[4:0]};
      assign fifo_push = beat_ok;
      assign fifo_din  = bus_rdata;
      assign fifo_pop  = rd_fire;
      assign space_ok  = !fifo_full;
      always_ff @(posedge clk) begin
        if (rst)                         ao_rd_data <= '0;
        else if (rd_fire && !fifo_empty) ao_rd_data <= fifo_head;
      end
    end
  endgenerate

  assign go = chan_en && (cnt_q != '0) && !irq_err && space_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      irq_done  <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      if (cnt_wr) begin
        irq_done <= 1'b0;
        irq_err  <= 1'b0;
      end
      case (st)
        ST_IDLE: begin
          if (go) begin
            bus_req <= 1'b1;
            st      <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (!go) begin
            bus_req <= 1'b0;
            st      <= ST_IDLE;
          end else if (bus_gnt) begin
            bus_valid <= 1'b1;
            bus_addr  <= addr_q;
            bus_wdata <= TO_MEM ? fifo_head : '0;
            st        <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (bus_err) begin
            bus_valid <= 1'b0;
            bus_req   <= 1'b0;
            irq_err   <= 1'b1;
            st        <= ST_IDLE;
          end else if (bus_ack) begin
            bus_valid <= 1'b0;
            if (cnt_q == LAST_BEAT) begin
              bus_req  <= 1'b0;
              irq_done <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              st <= ST_REQ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(bus_gnt) && $past(bus_req));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ack && !bus_err |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata));

  // R6
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q == '0 && $past(cnt_q == '0) |-> !bus_req);

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_err |=> !bus_req && irq_err && $stable(addr_q) && $stable(cnt_q));

  // R9
  done_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ack && !bus_err && cnt_q == LAST_BEAT |=> irq_done && !bus_req);
endmodule

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAT = 32'hA5A5_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  cfg0, cfg1;
  logic        en0 = 0, en1 = 0;
  logic        hwe0 = 0, hsel0 = 0, awe0 = 0, asel0 = 0;
  logic        hwe1 = 0, hsel1 = 0, awe1 = 0, asel1 = 0;
  logic [31:0] hwd0 = 0, awd0 = 0, hwd1 = 0, awd1 = 0;
  logic        wr_n0 = 1, rd_n0 = 1, wr_n1 = 1, rd_n1 = 1;
  logic [31:0] wrd0 = 0, wrd1 = 0, rdd0, rdd1;
  logic        req0, req1, gnt0 = 0, gnt1 = 0, val0, val1, we0, we1;
  logic [31:0] addr0, addr1, wdat0, wdat1, rdat0 = 0, rdat1 = 0;
  logic        ack0 = 0, ack1 = 0, err0 = 0, err1 = 0;
  logic        irqd0, irqd1, irqe0, irqe1;

  dma_chan #(.TO_MEM(1'b1)) u0 (
    .clk(clk), .rst(rst), .cfg_byte(cfg0), .chan_en(en0),
    .host_we(hwe0), .host_sel(hsel0), .host_wdata(hwd0),
    .ao_we(awe0), .ao_sel(asel0), .ao_wdata(awd0),
    .ao_wr_n(wr_n0), .ao_wr_data(wrd0), .ao_rd_n(rd_n0), .ao_rd_data(rdd0),
    .bus_req(req0), .bus_gnt(gnt0), .bus_valid(val0), .bus_we(we0),
    .bus_addr(addr0), .bus_wdata(wdat0), .bus_rdata(rdat0),
    .bus_ack(ack0), .bus_err(err0), .irq_done(irqd0), .irq_err(irqe0)
  );

  dma_chan #(.TO_MEM(1'b0)) u1 (
    .clk(clk), .rst(rst), .cfg_byte(cfg1), .chan_en(en1),
    .host_we(hwe1), .host_sel(hsel1), .host_wdata(hwd1),
    .ao_we(awe1), .ao_sel(asel1), .ao_wdata(awd1),
    .ao_wr_n(wr_n1), .ao_wr_data(wrd1), .ao_rd_n(rd_n1), .ao_rd_data(rdd1),
    .bus_req(req1), .bus_gnt(gnt1), .bus_valid(val1), .bus_we(we1),
    .bus_addr(addr1), .bus_wdata(wdat1), .bus_rdata(rdat1),
    .bus_ack(ack1), .bus_err(err1), .irq_done(irqd1), .irq_err(irqe1)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int beats0 = 0, beats1 = 0;
  int m0_cnt = 0, m1_cnt = 0;
  bit gen0 = 0, gen1 = 0, errm0 = 0;
  logic [31:0] exp0_a[$], exp0_d[$], exp1_a[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // register write from the host (h=1) or add-on (h=0) side of instance i
  task automatic rwr(input int i, input bit h, input bit sel, input logic [31:0] d);
    @(negedge clk);
    if (i == 0) begin
      if (h) begin hwe0 = 1; hsel0 = sel; hwd0 = d; end
      else   begin awe0 = 1; asel0 = sel; awd0 = d; end
    end else begin
      if (h) begin hwe1 = 1; hsel1 = sel; hwd1 = d; end
      else   begin awe1 = 1; asel1 = sel; awd1 = d; end
    end
    @(negedge clk);
    hwe0 = 0; awe0 = 0; hwe1 = 0; awe1 = 0;
  endtask

  task automatic push0(input logic [31:0] d, input int lowlen);
    @(negedge clk);
    wrd0 = d;
    wr_n0 = 0;
    tick(lowlen);
    wr_n0 = 1;
    tick(4);
  endtask

  // model of the memory target and per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (cyc > 50000) begin
        chk(0, "watchdog R6", cyc, 50000);
        finish_run();
      end
      // instance 0: toward memory
      if (ack0) begin
        ack0 = 0;
        m0_cnt -= 4;
      end else if (err0) begin
        err0 = 0;
      end else if (val0) begin
        beats0++;
        if (exp0_a.size() == 0) chk(0, "R7 unexpected beat u0", addr0, 0);
        else begin
          logic [31:0] ea, ed;
          ea = exp0_a.pop_front();
          ed = exp0_d.pop_front();
          chk(addr0 == ea, "R8 u0 beat address", addr0, ea);
          chk(wdat0 == ed, "R7 u0 beat data", wdat0, ed);
          chk(we0 == 1'b1, "R7 u0 beat write", {31'd0, we0}, 1);
        end
        if (errm0) err0 = 1; else ack0 = 1;
      end
      if (m0_cnt == 0) chk(!req0, "R6 u0 request with zero count", {31'd0, req0}, 0);
      gnt0 = req0 & gen0;
      // instance 1: from memory
      if (ack1) begin
        ack1 = 0;
        m1_cnt -= 4;
      end else if (val1) begin
        beats1++;
        if (exp1_a.size() == 0) chk(0, "R7 unexpected beat u1", addr1, 0);
        else begin
          logic [31:0] ea;
          ea = exp1_a.pop_front();
          chk(addr1 == ea, "R8 u1 beat address", addr1, ea);
          chk(we1 == 1'b0, "R7 u1 beat read", {31'd0, we1}, 0);
        end
        rdat1 = addr1 ^ PAT;
        ack1 = 1;
      end
      if (m1_cnt == 0) chk(!req1, "R6 u1 request with zero count", {31'd0, req1}, 0);
      gnt1 = req1 & gen1;
    end
  end

  initial begin
    cfg0 = 8'hE0;
    cfg1 = 8'h00;
    tick(3);
    // R1 reset state
    chk(!req0 && !val0 && !irqd0 && !irqe0, "R1 u0 reset outputs", {req0, val0, irqd0, irqe0}, 0);
    chk(!req1 && !val1 && !irqd1 && !irqe1, "R1 u1 reset outputs", {req1, val1, irqd1, irqe1}, 0);
    rst = 0;
    // R3: swap configuration after reset
    cfg0 = 8'h00;
    cfg1 = 8'hE0;
    tick(2);

    // ---- u0: host owner, edge strobes
    rwr(0, 1, 0, 32'h0000_1000);
    rwr(0, 0, 0, 32'h0000_7770);        // R2 add-on write ignored
    rwr(0, 1, 1, 32'd14);               // R8 becomes 12
    m0_cnt = 12;
    en0 = 1;
    tick(4);
    chk(!req0, "R6 u0 no request with empty FIFO", {31'd0, req0}, 0);
    exp0_a.push_back(32'h1000); exp0_d.push_back(32'hD000_0000);
    exp0_a.push_back(32'h1004); exp0_d.push_back(32'hD000_0001);
    exp0_a.push_back(32'h1008); exp0_d.push_back(32'hD000_0002);
    push0(32'hD000_0000, 6);            // R4 long low pulse moves one word
    chk(req0 == 1'b1, "R6 u0 request with data", {31'd0, req0}, 1);
    chk(!val0, "R7 u0 no beat without grant", {31'd0, val0}, 0);
    push0(32'hD000_0001, 1);
    push0(32'hD000_0002, 1);
    tick(3);
    chk(!val0 && beats0 == 0, "R7 u0 still waiting for grant", beats0, 0);
    gen0 = 1;
    tick(20);
    chk(beats0 == 3, "R4 u0 beat count", beats0, 3);
    chk(irqd0 == 1'b1, "R9 u0 done flag", {31'd0, irqd0}, 1);
    chk(!req0 && !irqe0, "R9 u0 request dropped", {req0, irqe0}, 0);

    // R10 error then retry
    rwr(0, 1, 0, 32'h0000_2000);
    rwr(0, 1, 1, 32'd8);
    m0_cnt = 8;
    chk(irqd0 == 1'b0, "R9 u0 count write clears done", {31'd0, irqd0}, 0);
    errm0 = 1;
    exp0_a.push_back(32'h2000); exp0_d.push_back(32'hD000_0003);
    push0(32'hD000_0003, 1);
    push0(32'hD000_0004, 1);
    tick(10);
    chk(irqe0 == 1'b1, "R10 u0 error flag", {31'd0, irqe0}, 1);
    chk(!req0 && beats0 == 4, "R10 u0 stopped after error", beats0, 4);
    errm0 = 0;
    exp0_a.push_back(32'h2000); exp0_d.push_back(32'hD000_0003);
    exp0_a.push_back(32'h2004); exp0_d.push_back(32'hD000_0004);
    rwr(0, 1, 1, 32'd8);
    chk(irqe0 == 1'b0, "R9 u0 count write clears error", {31'd0, irqe0}, 0);
    tick(20);
    chk(beats0 == 6 && irqd0, "R10 u0 retry completes", beats0, 6);

    // ---- u1: add-on owner, level strobes
    rwr(1, 1, 0, 32'h0000_5550);        // R2 host write ignored
    rwr(1, 0, 0, 32'h0000_3000);
    rwr(1, 0, 1, 32'd16);
    m1_cnt = 16;
    for (int k = 0; k < 4; k++) exp1_a.push_back(32'h3000 + 32'(4 * k));
    gen1 = 1;
    en1 = 1;
    tick(20);
    chk(beats1 == 4, "R2 u1 beat count", beats1, 4);
    chk(irqd1 == 1'b1, "R9 u1 done flag", {31'd0, irqd1}, 1);
    @(negedge clk);
    rd_n1 = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rdd1 == ((32'h3000 + 32'(4 * k)) ^ PAT), "R5 u1 level read data", rdd1,
          (32'h3000 + 32'(4 * k)) ^ PAT);
    end
    rd_n1 = 1;
    tick(2);
    rd_n1 = 0;
    tick(1);
    rd_n1 = 1;
    tick(2);
    chk(rdd1 == (32'h300C ^ PAT), "R1 u1 pop on empty ignored", rdd1, 32'h300C ^ PAT);

    // R11 transfer longer than the FIFO
    rwr(1, 0, 0, 32'h0000_4000);
    for (int k = 0; k < 10; k++) exp1_a.push_back(32'h4000 + 32'(4 * k));
    rwr(1, 0, 1, 32'd40);
    m1_cnt = 40;
    tick(30);
    chk(beats1 == 12, "R11 u1 stops at FIFO depth", beats1, 12);
    chk(!req1 && !irqd1, "R11 u1 waits for space", {req1, irqd1}, 0);
    rd_n1 = 0;
    @(negedge clk);
    chk(rdd1 == (32'h4000 ^ PAT), "R5 u1 first queued word", rdd1, 32'h4000 ^ PAT);
    @(negedge clk);
    rd_n1 = 1;
    chk(rdd1 == (32'h4004 ^ PAT), "R5 u1 second queued word", rdd1, 32'h4004 ^ PAT);
    tick(20);
    chk(beats1 == 14 && irqd1, "R11 u1 resumes and completes", beats1, 14);
    chk(m1_cnt == 0 && !req1, "R6 u1 idle at end", {31'd0, req1}, 0);
    finish_run();
  end
endmodule